// File: doc/BRIEF.md
# Gated Edge Capture with Timestamp Queue

This block watches one digital input, sampled once per coarse clock cycle, and turns its transitions into timestamped events while a gate window is open. Software opens the gate with a one-cycle pulse that also picks which transitions count: low-to-high, high-to-low, both, or none. It closes the window with another pulse. Each qualifying transition stores the value of a free-running timestamp input in a queue. A read port with one cycle of latency drains the queue. A counter reports how many transitions were seen in the latest window.

A transition is found by comparing this cycle's sample with the previous cycle's sample, so the block reports at most one event per coarse cycle. The sample pair keeps updating while the gate is closed. A level that was already high therefore does not look like an edge when the gate opens. When the queue is full, new events are discarded and a sticky overflow flag is raised. That flag is copied onto every read result until it is cleared explicitly.

Top module: `gated_edge_capture`

## Requirements
- R1: After a synchronous reset, `rd_valid`, `rd_ovf`, `ovf_flag` and `gate_active` are 0 and `edge_count` is 0.
- R2: Gate mode 2'b01 records only 0-to-1 transitions of `din`. A change of `din` ahead of clock edge k is written at edge k+1, with the `ts` value present at edge k+1.
- R3: Gate mode 2'b10 records only 1-to-0 transitions, with the same timing as R2.
- R4: Gate mode 2'b11 records transitions in both directions. Gate mode 2'b00 records none.
- R5: Transitions are ignored while `gate_active` is 0, and `edge_count` does not change. A level that is already high when a low-to-high gate opens produces no event.
- R6: `gate_open` sets `gate_active`, latches `gate_mode` and clears `edge_count` at the same edge. `gate_close` clears `gate_active` and wins over `gate_open`. `edge_count` counts every transition recorded in the window, including dropped ones, and holds its value after close.
- R7: `rd_en` with a non-empty queue gives `rd_valid` high one edge later, with the oldest stored timestamp on `rd_ts`. `rd_en` with an empty queue gives no `rd_valid`.
- R8: The queue holds DEPTH entries (default 64). An event that arrives while it is full is discarded and the stored entries are kept, even if a read happens in the same cycle.
- R9: A discarded event sets `ovf_flag` at the edge where it is dropped. The flag stays set until `ovf_clear`, and a drop in the same cycle wins over the clear. `rd_ovf` carries the flag value along with every read result.
- R10: When `din` toggles every cycle in both-edge mode, exactly one event is recorded per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Monitored digital input |
| ts | input | TS_W | Free-running timestamp |
| gate_open | input | 1 | Pulse: open window, latch mode, clear count |
| gate_close | input | 1 | Pulse: close window |
| gate_mode | input | 2 | 01 rise, 10 fall, 11 both, 00 none |
| rd_en | input | 1 | Pop request |
| ovf_clear | input | 1 | Clear sticky overflow |
| rd_valid | output | 1 | Read result valid |
| rd_ts | output | TS_W | Popped timestamp |
| rd_ovf | output | 1 | Overflow flag attached to the read result |
| ovf_flag | output | 1 | Sticky overflow flag |
| gate_active | output | 1 | Window open |
| edge_count | output | CNT_W | Transitions in the current or last window |

## Verification
An input change driven before clock edge k enters the queue and `edge_count` at edge k+1, carrying the timestamp of that edge. A read result appears one edge after `rd_en`. The overflow flag moves at the edge of the drop or the clear. The bench drives inputs and advances `ts` on falling edges. For each input change it works out that the stored stamp is the `ts` value seen just after the drive plus one. A scoreboard queue receives these expected stamps, and a monitor compares them, together with the expected overflow bit, at the falling edge after each read. Count and flag checks are made only once the gate has been closed and the pipeline has settled.

// File: rtl/gec_pkg.sv
package gec_pkg;
  typedef enum logic [1:0] {
    GM_NONE = 2'b00,
    GM_RISE = 2'b01,
    GM_FALL = 2'b10,
    GM_BOTH = 2'b11
  } gate_mode_e;

  function automatic logic edge_match(gate_mode_e m, logic cur, logic prv);
    logic up;
    logic dn;
    up = cur & ~prv;
    dn = ~cur & prv;
    case (m)
      GM_RISE: edge_match = up;
      GM_FALL: edge_match = dn;
      GM_BOTH: edge_match = up | dn;
      default: edge_match = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gec_sampler.sv
module gec_sampler (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic cur_q,
  output logic prv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= 1'b0;
      prv_q <= 1'b0;
    end else begin
      cur_q <= din;
      prv_q <= cur_q;
    end
  end
endmodule

// File: rtl/gec_gate.sv
module gec_gate
  import gec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [1:0]       mode_i,
  input  logic             hit_i,
  output logic             active_q,
  output gate_mode_e       mode_q,
  output logic [CNT_W-1:0] count_q
);
  logic start;
  assign start = open_i & ~close_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      mode_q   <= GM_NONE;
      count_q  <= '0;
    end else begin
      if (close_i) begin
        active_q <= 1'b0;
      end else if (open_i) begin
        active_q <= 1'b1;
        mode_q   <= gate_mode_e'(mode_i);
      end
      if (start) begin
        count_q <= '0;
      end else if (active_q && hit_i) begin
        count_q <= count_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gec_fifo.sv
module gec_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          drop,
  output logic          rd_fire
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic          full;
  logic          wr_ok;

  assign full    = (level == FULL);
  assign wr_ok   = wr_en & ~full;
  assign drop    = wr_en & full;
  assign rd_fire = rd_en & (level != '0);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      level    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (wr_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_fire) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/gated_edge_capture.sv
module gated_edge_capture
  import gec_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [TS_W-1:0]  ts,
  input  logic             gate_open,
  input  logic             gate_close,
  input  logic [1:0]       gate_mode,
  input  logic             rd_en,
  input  logic             ovf_clear,
  output logic             rd_valid,
  output logic [TS_W-1:0]  rd_ts,
  output logic             rd_ovf,
  output logic             ovf_flag,
  output logic             gate_active,
  output logic [CNT_W-1:0] edge_count
);
  logic          cur_s;
  logic          prv_s;
  gate_mode_e    mode_q;
  logic          hit;
  logic          wr_evt;
  logic [LW-1:0] fifo_level;
  logic          drop;
  logic          rd_fire;

  gec_sampler u_smp (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .cur_q (cur_s),
    .prv_q (prv_s)
  );

  assign hit    = edge_match(mode_q, cur_s, prv_s);
  assign wr_evt = hit & gate_active;

  gec_gate #(.CNT_W(CNT_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .open_i   (gate_open),
    .close_i  (gate_close),
    .mode_i   (gate_mode),
    .hit_i    (hit),
    .active_q (gate_active),
    .mode_q   (mode_q),
    .count_q  (edge_count)
  );

  gec_fifo #(.DEPTH(DEPTH), .W(TS_W)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_evt),
    .wr_data  (ts),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .rd_data  (rd_ts),
    .level    (fifo_level),
    .drop     (drop),
    .rd_fire  (rd_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      rd_ovf   <= 1'b0;
    end else begin
      if (drop) ovf_flag <= 1'b1;
      else if (ovf_clear) ovf_flag <= 1'b0;
      if (rd_fire) rd_ovf <= ovf_flag;
    end
  end
endmodule

// File: rtl/gec_checker.sv
module gec_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             gate_open,
  input logic             gate_active,
  input logic [CNT_W-1:0] edge_count,
  input logic             ovf_flag,
  input logic             ovf_clear,
  input logic [LW-1:0]    fifo_level,
  input logic             drop
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!rd_valid && !ovf_flag && !gate_active && edge_count == '0));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && fifo_level == '0) |=> !rd_valid);

  p_closed_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!gate_active && !gate_open) |=> $stable(edge_count));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  p_drop_sets_r9: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf_flag);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  p_one_step_r10: assert property (@(posedge clk) disable iff (rst)
    (gate_active && !gate_open) |=>
      (edge_count == $past(edge_count) ||
       edge_count == CNT_W'($past(edge_count) + 1'b1)));
endmodule

bind gated_edge_capture gec_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .gate_open  (gate_open),
  .gate_active(gate_active),
  .edge_count (edge_count),
  .ovf_flag   (ovf_flag),
  .ovf_clear  (ovf_clear),
  .fifo_level (fifo_level),
  .drop       (drop)
);

// File: tb/tb_gated_edge_capture.sv
module tb_gated_edge_capture;
  localparam int TS_W  = 32;
  localparam int DEPTH = 64;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             din = 1'b0;
  logic [TS_W-1:0]  ts = '0;
  logic             gate_open = 1'b0;
  logic             gate_close = 1'b0;
  logic [1:0]       gate_mode = 2'b00;
  logic             rd_en = 1'b0;
  logic             ovf_clear = 1'b0;
  logic             rd_valid;
  logic [TS_W-1:0]  rd_ts;
  logic             rd_ovf;
  logic             ovf_flag;
  logic             gate_active;
  logic [CNT_W-1:0] edge_count;

  gated_edge_capture #(.TS_W(TS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .din(din), .ts(ts),
    .gate_open(gate_open), .gate_close(gate_close), .gate_mode(gate_mode),
    .rd_en(rd_en), .ovf_clear(ovf_clear),
    .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_ovf(rd_ovf),
    .ovf_flag(ovf_flag), .gate_active(gate_active), .edge_count(edge_count)
  );

  always #4 clk = ~clk;
  always @(negedge clk) ts <= ts + 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [TS_W-1:0] exp_q[$];
  int  lvl_m = 0;
  int  cnt_m = 0;
  bit  gate_m = 1'b0;
  logic [1:0] mode_m = 2'b00;
  bit  prev_m = 1'b0;
  bit  ovf_m = 1'b0;
  string cur_req = "R2";

  task automatic check_eq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: R7 order/latency, R9 rd_ovf
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check_eq("R7 unexpected read", 1, 0);
      end else begin
        check_eq(cur_req, longint'(rd_ts), longint'(exp_q.pop_front()));
        check_eq("R9 rd_ovf", longint'(rd_ovf), longint'(ovf_m));
      end
    end
  end

  task automatic drive(bit v);
    bit hit;
    @(negedge clk);
    din = v;
    #1;
    hit = 1'b0;
    if (gate_m) begin
      case (mode_m)
        2'b01: hit = v & ~prev_m;
        2'b10: hit = ~v & prev_m;
        2'b11: hit = v ^ prev_m;
        default: hit = 1'b0;
      endcase
    end
    prev_m = v;
    if (hit) begin
      cnt_m++;
      if (lvl_m < DEPTH) begin
        exp_q.push_back(ts + 1'b1);
        lvl_m++;
      end else begin
        ovf_m = 1'b1;
      end
    end
  endtask

  task automatic open_gate(logic [1:0] m);
    @(negedge clk);
    gate_open = 1'b1;
    gate_mode = m;
    @(negedge clk);
    gate_open = 1'b0;
    gate_m = 1'b1;
    mode_m = m;
    cnt_m = 0;
  endtask

  task automatic close_gate();
    repeat (2) @(negedge clk);
    gate_close = 1'b1;
    gate_m = 1'b0;
    @(negedge clk);
    gate_close = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    while (lvl_m > 0) begin
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      lvl_m--;
    end
    repeat (2) @(negedge clk);
    check_eq("R7 scoreboard empty", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 rd_valid", rd_valid, 0);
    check_eq("R1 rd_ovf", rd_ovf, 0);
    check_eq("R1 ovf_flag", ovf_flag, 0);
    check_eq("R1 gate_active", gate_active, 0);
    check_eq("R1 edge_count", edge_count, 0);

    // R7 read on empty queue
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check_eq("R7 empty read", rd_valid, 0);

    // R2 rising only
    cur_req = "R2 rising ts";
    open_gate(2'b01);
    check_eq("R6 gate_active", gate_active, 1);
    check_eq("R6 count cleared", edge_count, 0);
    drive(1); drive(1); drive(0); drive(0); drive(1); drive(0); drive(1); drive(0);
    close_gate();
    check_eq("R2 count", edge_count, cnt_m);
    check_eq("R2 expected three", cnt_m, 3);
    drain();

    // R3 falling only
    cur_req = "R3 falling ts";
    open_gate(2'b10);
    drive(1); drive(0); drive(1); drive(1); drive(0);
    close_gate();
    check_eq("R3 count", edge_count, 2);
    drain();

    // R4 both and none
    cur_req = "R4 both ts";
    open_gate(2'b11);
    drive(1); drive(1); drive(0); drive(1); drive(0);
    close_gate();
    check_eq("R4 both count", edge_count, 4);
    drain();
    open_gate(2'b00);
    drive(1); drive(0); drive(1); drive(0);
    close_gate();
    check_eq("R4 none count", edge_count, 0);
    drain();

    // R5 closed gate ignored, no false edge at open
    cur_req = "R5 ts";
    open_gate(2'b11);
    drive(1);
    close_gate();
    check_eq("R6 held count", edge_count, 1);
    drive(0); drive(1); drive(0); drive(1);
    repeat (3) @(negedge clk);
    check_eq("R5 closed count", edge_count, 1);
    drain();
    open_gate(2'b01);
    repeat (4) @(negedge clk);
    close_gate();
    check_eq("R5 no false edge", edge_count, 0);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check_eq("R5 queue empty", rd_valid, 0);
    drive(0);

    // R8/R9/R10 toggle every cycle, overflow
    cur_req = "R8 ts";
    open_gate(2'b11);
    for (int i = 0; i < DEPTH + 6; i++) drive(i[0] ? 1'b0 : 1'b1);
    close_gate();
    check_eq("R10 one per cycle", edge_count, DEPTH + 6);
    check_eq("R8 kept", lvl_m, DEPTH);
    check_eq("R9 ovf_flag set", ovf_flag, 1);
    drain();
    check_eq("R9 ovf sticky after reads", ovf_flag, 1);
    @(negedge clk); ovf_clear = 1'b1;
    @(negedge clk); ovf_clear = 1'b0; ovf_m = 1'b0;
    check_eq("R9 ovf cleared", ovf_flag, 0);
    cur_req = "R9 ts after clear";
    open_gate(2'b01);
    drive(1);
    close_gate();
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule